// File: doc/BRIEF.md
# Tiny Load-Store Processor Core

This block is a minimal single-cycle processor. Each instruction is one byte and completes in a single clock. The core holds four 8-bit general registers and an 8-bit program counter that counts instructions. Only the add instruction does arithmetic, and it works between registers. A 64-byte data memory inside the block is reached only through explicit load and store instructions. Both use a register base plus a small unsigned displacement.

The program is fixed when the block is instantiated. The `PROGRAM` parameter fills an internal instruction ROM, and the `DMEM_INIT` parameter gives the image that reset copies into data memory. Register values, memory contents and program progress can be observed only through the debug outputs and the halt flag. The core stops by itself when its program counter runs past the last ROM entry. It also stops when it takes a branch whose target is the branch itself.

Top module: `tiny_ls_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the PC and all four registers to zero and reloads every data memory byte from `DMEM_INIT`. Byte a of the image is bits [8a+7:8a].
- R2: Bits [7:6] hold the opcode: 00 add, 01 load, 10 store, 11 branch-if-equal. Add takes rd=[5:4], rs=[3:2] and rt=[1:0]. It writes rs+rt into rd, leaves the other registers unchanged and advances the PC by one.
- R3: Load takes rt=[5:4], base=[3:2] and an unsigned displacement in [1:0]. It writes the memory byte at base+displacement into rt and advances the PC by one.
- R4: Store uses the same fields as load. It writes rt to the byte at base+displacement, changes no register and advances the PC by one.
- R5: Branch compares the register in [5:4] with the register in [3:2]. Bits [1:0] hold a two's-complement offset from -2 to +1. When the two registers are equal the next PC is PC+1+offset; otherwise it is PC+1. No register changes.
- R6: Data addresses are the low 6 bits of base+displacement, so the address wraps modulo 64.
- R7: When the PC is at or beyond the ROM depth, `halt` is high. The PC, the registers and the memory then hold.
- R8: A taken branch with offset -1 (field 11) holds the PC in place and raises `halt`. The same branch with unequal registers falls through without halting.
- R9: Add wraps modulo 256. When rd is also a source, the add uses the register's value from before the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | output | 1 | High while the core is stopped (end of ROM or branch to self) |
| dbg_pc | output | 8 | Current program counter, in instructions |
| dbg_regs | output | 32 | Register file; r0 in [7:0], r1 in [15:8], r2 in [23:16], r3 in [31:24] |

## Verification
Backward branches are the hardest situation to reach. Every register starts at zero after reset, and the only source of other values is the memory image. A loop must take its backward branch a fixed number of times and must never spin. The bench program therefore loads a zero byte through an address that wraps past 63. It copies a value x into one register and 2x into another, then loops on a self-doubling add. The branch back is taken exactly once, and the loop exits when 4x differs from 2x. A second instance holds a two-instruction program that ends in a taken branch to self. A reference model of the instruction set, kept in the bench, predicts the PC and the registers after every clock.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
   localparam int INSTR_W  = 8;
   localparam int RIDX_W   = 2;
   localparam int NUM_REGS = 4;

   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_LOAD  = 2'b01,
      OP_STORE = 2'b10,
      OP_BEQ   = 2'b11
   } tlc_op_e;

   typedef struct packed {
      tlc_op_e     op;
      logic [1:0]  f_hi;
      logic [1:0]  f_mid;
      logic [1:0]  f_lo;
   } tlc_instr_t;
endpackage

// File: rtl/tlc_irom.sv
module tlc_irom #(
   parameter int PC_W  = 8,
   parameter int DEPTH = 32,
   parameter logic [DEPTH*8-1:0] PROGRAM = '0
) (
   input  logic [PC_W-1:0] pc,
   output logic [7:0]      word
);
   // Out-of-range PC reads as zero; the core masks it via halt.
   always_comb begin
      word = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (pc == PC_W'(i)) word = PROGRAM[i*8 +: 8];
      end
   end
endmodule

// File: rtl/tlc_decode.sv
module tlc_decode
   import tlc_pkg::*;
(
   input  tlc_instr_t        instr,
   output logic [RIDX_W-1:0] a_idx,
   output logic [RIDX_W-1:0] b_idx,
   output logic [RIDX_W-1:0] w_idx,
   output logic              reg_we,
   output logic              mem_we,
   output logic              is_load,
   output logic              is_branch,
   output logic [1:0]        imm2
);
   always_comb begin
      a_idx     = instr.f_mid;
      b_idx     = instr.f_lo;
      w_idx     = instr.f_hi;
      reg_we    = 1'b0;
      mem_we    = 1'b0;
      is_load   = 1'b0;
      is_branch = 1'b0;
      imm2      = instr.f_lo;
      unique case (instr.op)
         OP_ADD: begin
            reg_we = 1'b1;
         end
         OP_LOAD: begin
            b_idx   = instr.f_hi;
            reg_we  = 1'b1;
            is_load = 1'b1;
         end
         OP_STORE: begin
            b_idx  = instr.f_hi;
            mem_we = 1'b1;
         end
         OP_BEQ: begin
            a_idx     = instr.f_hi;
            b_idx     = instr.f_mid;
            is_branch = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tlc_regfile.sv
module tlc_regfile #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [IDX_W-1:0]           w_idx,
   input  logic [DATA_W-1:0]          w_data,
   input  logic [IDX_W-1:0]           a_idx,
   input  logic [IDX_W-1:0]           b_idx,
   output logic [DATA_W-1:0]          a_data,
   output logic [DATA_W-1:0]          b_data,
   output logic [NUM_REGS*DATA_W-1:0] all_regs
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk) begin
         if (rst)                                r_q <= '0;
         else if (we && (w_idx == IDX_W'(g)))    r_q <= w_data;
      end
      assign all_regs[g*DATA_W +: DATA_W] = r_q;
   end

   assign a_data = all_regs[a_idx*DATA_W +: DATA_W];
   assign b_data = all_regs[b_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/tlc_dmem.sv
module tlc_dmem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter logic [DEPTH*DATA_W-1:0] INIT = '0,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] w_data,
   output logic [DATA_W-1:0] r_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= INIT[a*DATA_W +: DATA_W];
      end else if (we) begin
         mem[addr] <= w_data;
      end
   end

   assign r_data = mem[addr];
endmodule

// File: rtl/tiny_ls_core.sv
module tiny_ls_core
   import tlc_pkg::*;
#(
   parameter int PC_W       = 8,
   parameter int DATA_W     = 8,
   parameter int ROM_DEPTH  = 32,
   parameter int DMEM_DEPTH = 64,
   parameter logic [ROM_DEPTH*INSTR_W-1:0]  PROGRAM   = '0,
   parameter logic [DMEM_DEPTH*DATA_W-1:0]  DMEM_INIT = '0
) (
   input  logic                       clk,
   input  logic                       rst,
   output logic                       halt,
   output logic [PC_W-1:0]            dbg_pc,
   output logic [NUM_REGS*DATA_W-1:0] dbg_regs
);
   localparam int DMEM_AW = $clog2(DMEM_DEPTH);
   localparam logic [PC_W-1:0] PC_END = PC_W'(ROM_DEPTH);

   if (ROM_DEPTH < 1 || ROM_DEPTH >= (1 << PC_W)) begin : g_bad_rom
      $error("ROM_DEPTH must lie in 1 .. 2**PC_W-1");
   end
   if ((1 << DMEM_AW) != DMEM_DEPTH || DMEM_AW > DATA_W) begin : g_bad_dmem
      $error("DMEM_DEPTH must be a power of two addressable by DATA_W bits");
   end
   if (PC_W < 3) begin : g_bad_pc
      $error("PC_W must be at least 3");
   end

   logic [PC_W-1:0]    pc_q;
   logic [7:0]         rom_word;
   tlc_instr_t         instr;
   logic [RIDX_W-1:0]  a_idx, b_idx, w_idx;
   logic               dec_reg_we, dec_mem_we, is_load, is_branch;
   logic [1:0]         imm2;
   logic [DATA_W-1:0]  a_data, b_data, mem_rdata, w_data;
   logic [DMEM_AW-1:0] mem_addr;
   logic               taken, self_loop, at_end;
   logic [PC_W-1:0]    pc_inc, pc_br;

   tlc_irom #(.PC_W(PC_W), .DEPTH(ROM_DEPTH), .PROGRAM(PROGRAM)) u_irom (
      .pc(pc_q), .word(rom_word)
   );
   assign instr = tlc_instr_t'(rom_word);

   tlc_decode u_dec (
      .instr(instr), .a_idx(a_idx), .b_idx(b_idx), .w_idx(w_idx),
      .reg_we(dec_reg_we), .mem_we(dec_mem_we), .is_load(is_load),
      .is_branch(is_branch), .imm2(imm2)
   );

   // Branch resolution and stop conditions
   assign taken     = is_branch && (a_data == b_data);
   assign self_loop = taken && (imm2 == 2'b11);
   assign at_end    = (pc_q >= PC_END);
   assign halt      = at_end || self_loop;
   assign pc_inc    = pc_q + PC_W'(1);
   assign pc_br     = pc_inc + {{(PC_W-2){imm2[1]}}, imm2};

   assign mem_addr = DMEM_AW'(a_data) + DMEM_AW'(imm2);
   assign w_data   = is_load ? mem_rdata : (a_data + b_data);

   tlc_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
      .clk(clk), .rst(rst), .we(dec_reg_we && !halt), .w_idx(w_idx),
      .w_data(w_data), .a_idx(a_idx), .b_idx(b_idx),
      .a_data(a_data), .b_data(b_data), .all_regs(dbg_regs)
   );

   tlc_dmem #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH), .INIT(DMEM_INIT)) u_dmem (
      .clk(clk), .rst(rst), .we(dec_mem_we && !halt), .addr(mem_addr),
      .w_data(b_data), .r_data(mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst)        pc_q <= '0;
      else if (halt)  pc_q <= pc_q;
      else if (taken) pc_q <= pc_br;
      else            pc_q <= pc_inc;
   end

   assign dbg_pc = pc_q;
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
   parameter int PC_W      = 8,
   parameter int DATA_W    = 8,
   parameter int ROM_DEPTH = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              halt,
   input logic [PC_W-1:0]   dbg_pc,
   input logic [4*DATA_W-1:0] dbg_regs,
   input logic [7:0]        instr
);
   localparam logic [PC_W-1:0] END_PC = PC_W'(ROM_DEPTH);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (dbg_pc == '0 && dbg_regs == '0));

   // R2
   seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
      (!halt && instr[7:6] != 2'b11) |=> dbg_pc == PC_W'($past(dbg_pc) + 1'b1));

   // R4
   store_regs_chk: assert property (@(posedge clk) disable iff (rst)
      (!halt && instr[7:6] == 2'b10) |=> $stable(dbg_regs));

   // R5
   branch_regs_chk: assert property (@(posedge clk) disable iff (rst)
      (instr[7:6] == 2'b11) |=> $stable(dbg_regs));

   // R7
   end_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (halt && dbg_pc >= END_PC) |=> ($stable(dbg_pc) && $stable(dbg_regs) && halt));

   // R8
   self_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (halt && dbg_pc < END_PC) |=> ($stable(dbg_pc) && halt));
endmodule

bind tiny_ls_core tlc_checker #(
   .PC_W(PC_W), .DATA_W(DATA_W), .ROM_DEPTH(ROM_DEPTH)
) u_chk (
   .clk(clk), .rst(rst), .halt(halt), .dbg_pc(dbg_pc),
   .dbg_regs(dbg_regs), .instr(instr)
);

// File: tb/test_tiny_ls_core.sv
module test_tiny_ls_core;
   localparam int DEPTH_A = 25;
   localparam int DEPTH_B = 4;
   localparam int DM      = 64;

   function automatic logic [7:0] e_add(int rd, int rs, int rt);
      return {2'b00, 2'(rd), 2'(rs), 2'(rt)};
   endfunction
   function automatic logic [7:0] e_lw(int rt, int rs, int d);
      return {2'b01, 2'(rt), 2'(rs), 2'(d)};
   endfunction
   function automatic logic [7:0] e_sw(int rt, int rs, int d);
      return {2'b10, 2'(rt), 2'(rs), 2'(d)};
   endfunction
   function automatic logic [7:0] e_beq(int rs, int rt, int off);
      return {2'b11, 2'(rs), 2'(rt), 2'(off)};
   endfunction

   function automatic logic [DEPTH_A*8-1:0] build_prog_a();
      logic [7:0] p [DEPTH_A];
      logic [DEPTH_A*8-1:0] v;
      p[0]  = e_lw (1, 0, 1);   p[1]  = e_lw (2, 0, 3);
      p[2]  = e_add(3, 1, 2);   p[3]  = e_add(3, 3, 3);
      p[4]  = e_add(3, 3, 2);   p[5]  = e_sw (3, 1, 2);
      p[6]  = e_lw (0, 1, 2);   p[7]  = e_sw (2, 3, 3);
      p[8]  = e_lw (1, 0, 3);   p[9]  = e_beq(1, 2, 1);
      p[10] = e_add(0, 0, 0);   p[11] = e_beq(1, 3, 1);
      p[12] = e_beq(0, 3, 0);   p[13] = e_lw (2, 3, 1);
      p[14] = e_add(1, 0, 2);   p[15] = e_add(3, 0, 0);
      p[16] = e_add(1, 1, 1);   p[17] = e_beq(1, 3, -2);
      p[18] = e_sw (1, 2, 0);   p[19] = e_lw (0, 2, 0);
      p[20] = e_beq(0, 3, -1);  p[21] = e_add(2, 3, 1);
      p[22] = e_sw (2, 2, 3);   p[23] = e_lw (3, 2, 3);
      p[24] = e_lw (1, 1, 1);
      for (int i = 0; i < DEPTH_A; i++) v[i*8 +: 8] = p[i];
      return v;
   endfunction

   function automatic logic [DEPTH_B*8-1:0] build_prog_b();
      logic [DEPTH_B*8-1:0] v;
      v = '0;
      v[7:0]  = e_lw(1, 0, 1);
      v[15:8] = e_beq(2, 3, -1);
      return v;
   endfunction

   function automatic logic [7:0] img_byte(int a);
      return 8'(a * 29);
   endfunction

   function automatic logic [DM*8-1:0] build_img();
      logic [DM*8-1:0] v;
      for (int a = 0; a < DM; a++) v[a*8 +: 8] = img_byte(a);
      return v;
   endfunction

   localparam logic [DEPTH_A*8-1:0] PROG_A = build_prog_a();
   localparam logic [DEPTH_B*8-1:0] PROG_B = build_prog_b();
   localparam logic [DM*8-1:0]      IMG    = build_img();

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic        halt_a, halt_b;
   logic [7:0]  pc_a, pc_b;
   logic [31:0] regs_a, regs_b;

   tiny_ls_core #(.ROM_DEPTH(DEPTH_A), .PROGRAM(PROG_A), .DMEM_INIT(IMG)) i_tiny_ls_core (
      .clk(clk), .rst(rst), .halt(halt_a), .dbg_pc(pc_a), .dbg_regs(regs_a)
   );
   tiny_ls_core #(.ROM_DEPTH(DEPTH_B), .PROGRAM(PROG_B), .DMEM_INIT(IMG)) i_tiny_ls_core_b (
      .clk(clk), .rst(rst), .halt(halt_b), .dbg_pc(pc_b), .dbg_regs(regs_b)
   );

   int n_run  = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Reference model of the instruction set
   logic [7:0] m_reg [4];
   logic [7:0] m_mem [DM];
   logic [7:0] m_pc;

   task automatic model_reset();
      m_pc = '0;
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      for (int a = 0; a < DM; a++) m_mem[a] = img_byte(a);
   endtask

   function automatic logic model_halted();
      logic [7:0] ins;
      if (int'(m_pc) >= DEPTH_A) return 1'b1;
      ins = PROG_A[int'(m_pc)*8 +: 8];
      return ins[7:6] == 2'b11 && ins[1:0] == 2'b11 &&
             m_reg[ins[5:4]] == m_reg[ins[3:2]];
   endfunction

   function automatic logic [40:0] model_vec();
      return {model_halted(), m_pc, m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
   endfunction

   task automatic model_step(output string tag);
      logic [7:0] ins;
      logic [8:0] s9;
      logic [7:0] sa;
      logic [7:0] off;
      if (model_halted()) begin
         tag = (int'(m_pc) >= DEPTH_A) ? "R7" : "R8";
         return;
      end
      ins = PROG_A[int'(m_pc)*8 +: 8];
      case (ins[7:6])
         2'b00: begin
            s9 = {1'b0, m_reg[ins[3:2]]} + {1'b0, m_reg[ins[1:0]]};
            tag = (s9[8] || ins[5:4] == ins[3:2] || ins[5:4] == ins[1:0]) ? "R9" : "R2";
            m_reg[ins[5:4]] = s9[7:0];
            m_pc = m_pc + 8'd1;
         end
         2'b01, 2'b10: begin
            sa = m_reg[ins[3:2]] + {6'b0, ins[1:0]};
            if (ins[7:6] == 2'b01) begin
               tag = (int'(m_reg[ins[3:2]]) + int'(ins[1:0]) >= DM) ? "R6" : "R3";
               m_reg[ins[5:4]] = m_mem[sa[5:0]];
            end else begin
               tag = (int'(m_reg[ins[3:2]]) + int'(ins[1:0]) >= DM) ? "R6" : "R4";
               m_mem[sa[5:0]] = m_reg[ins[5:4]];
            end
            m_pc = m_pc + 8'd1;
         end
         default: begin
            off = {{6{ins[1]}}, ins[1:0]};
            tag = (ins[1:0] == 2'b11) ? "R8" : "R5";
            if (m_reg[ins[5:4]] == m_reg[ins[3:2]]) m_pc = m_pc + 8'd1 + off;
            else                                   m_pc = m_pc + 8'd1;
         end
      endcase
   endtask

   task automatic run_cycles(input int n, input bool_b_checks);
      string tag;
      for (int c = 0; c < n; c++) begin
         model_step(tag);
         @(negedge clk);
         chk(tag, {23'b0, halt_a, pc_a, regs_a}, {23'b0, model_vec()});
         if (bool_b_checks && (c == 0 || c == 6)) begin
            // R8: branch-to-self at PC 1 after loading r1
            chk("R8", {23'b0, halt_b, pc_b, regs_b},
                {23'b0, 1'b1, 8'd1, 8'd0, 8'd0, img_byte(1), 8'd0});
         end
      end
   endtask

   task automatic check_reset_state();
      chk("R1", {23'b0, halt_a, pc_a, regs_a}, 64'd0);
      chk("R1", {23'b0, halt_b, pc_b, regs_b}, 64'd0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_reset_state();
      model_reset();
      run_cycles(40, 1'b1);
      chk("R7", {63'b0, halt_a}, 64'd1);
      chk("R7", {56'b0, pc_a}, 64'(DEPTH_A));

      // Reset after halt: memory image restored (second pass reloads a zero at byte 0)
      rst = 1'b1;
      @(negedge clk);
      chk("R1", {24'b0, pc_a, regs_a}, 64'd0);
      rst = 1'b0;
      model_reset();
      run_cycles(12, 1'b0);

      // Reset in the middle of a run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_reset_state();
      model_reset();
      run_cycles(40, 1'b1);
      chk("R7", {63'b0, halt_a}, 64'd1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog R7: run did not finish, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule